// File: doc/BRIEF.md
# Sensor Register File Serial Slave

This block is the two-wire serial slave front end of a small optical sensor. It watches oversampled clock and data lines from the bus pads and drives the data line through an open-drain enable. It finds START, repeated START and STOP conditions and answers one of two 7-bit addresses. A strap pin, sampled once after reset, picks the address. The first byte of a write transfer loads a 5-bit register pointer. Each later byte is stored at the pointer, and the pointer then steps forward by one. A read first sets the pointer with a short write, then issues a repeated START and the address with the read bit. Bytes then stream out from consecutive addresses until the master answers with NACK.

The register file holds the configuration of the sensing logic and returns the results of that logic. Measurement values and status flags come in as plain input pins. The whole writable register set goes out on one flat configuration bus. Some registers follow special access rules, listed below. The bus carries its own flow control through ACK/NACK, so the block has no valid/ready handshake: every accepted byte gets ACK, and the slave never holds the clock low.

Top module: `i2c_sensor_regif`

## Requirements
- R1: The device address is 0x5C when `addr_strap` is 0 and 0x23 when it is 1. The strap is captured once after reset, and later changes to it have no effect. A transfer to any other address gets no ACK, and the slave takes no part in it.
- R2: After an address match with the write bit (0), the first data byte loads the pointer from its low 5 bits. Each later byte is written to the pointer, and the pointer then increments.
- R3: In a read (write of the pointer, repeated START, address with the read bit 1), bytes come from consecutive addresses. The pointer increments after every byte and wraps from 0x1F to 0x00.
- R4: Bits travel MSB first. The slave pulls data low during the 9th clock pulse after a matching address and after every written byte, including bytes aimed at read-only or reserved addresses.
- R5: After the master answers a read byte with NACK, the slave releases the data line and waits for STOP or a repeated START. The data line is released out of reset.
- R6: Addresses 0x17 to 0x1F are reserved. Writes to them change nothing, and reads return 0x00.
- R7: Addresses 0x0E/0x0F return the low and high byte of `light_val`. 0x10/0x11 return `prox_val`, and 0x12/0x13 return `ir_val`, each as a low byte followed by a zero-extended high byte. Writes to these addresses are discarded.
- R8: Writing 1 to bit 6 of the control register (0x00) returns every register to its default: 0x01 = 0x40; 0x02, 0x03, 0x04, 0x05, 0x07, 0x09 and 0x0B = 0xFF; 0x06, 0x0A and 0x0C = 0x03; 0x08 = 0xBF; all other registers 0x00. Bit 6 then reads 0.
- R9: Register 0x01 has a light flag in bit 3 and a proximity flag in bit 4. A pulse on `light_flag_set` or `prox_flag_set` sets the flag. Writing 0 to a flag clears it, and writing 1 leaves it unchanged. Bit 5 reads `prox_near` and ignores writes. Bits 7:6 and 2:0 are plain read/write.
- R10: A write of 0x00 to register 0x02 or 0x03 is ignored, and the previous value stays.
- R11: Control bits 2 and 1 (sensing enables) latch only when bit 0 (power) is already 1 and the same write keeps bit 0 at 1. In every other case they read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 1 | Address select strap, captured after reset |
| scl_i | input | 1 | Bus clock line from the pad |
| sda_i | input | 1 | Bus data line from the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| light_val | input | 16 | Ambient light result |
| prox_val | input | PS_W | Proximity result |
| ir_val | input | PS_W | Background infrared result |
| prox_near | input | 1 | Near/far status shown in register 0x01 bit 5 |
| light_flag_set | input | 1 | One-cycle pulse that sets the light flag |
| prox_flag_set | input | 1 | One-cycle pulse that sets the proximity flag |
| cfg_flat | output | 8*23 | All registers, register n at bits 8n+7:8n |

## Verification
A bit-level bus master runs the main function in several ways. It sweeps a write burst across every address from 0x02 to 0x1F. It reads the whole map back in one burst, and it runs a short read that wraps at the top of the map. Together these separate the writable registers from the read-only and reserved ones, and they show that the pointer neither skips nor repeats an address. Each special rule then gets its own write patterns: zero into the timing registers, enables written with and without power, 1s and 0s written to the flags, and a soft reset after the registers have been changed. Each of these tells the special rule apart from a plain register store. Last, the strap is flipped across a reset and again after it, to show that only the value captured after reset selects the address.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;
  localparam int ADDR_W = 5;
  localparam int NREG   = 23;
  typedef logic [ADDR_W-1:0] raddr_t;

  localparam raddr_t REG_CTRL  = 5'h00;
  localparam raddr_t REG_INTR  = 5'h01;
  localparam raddr_t REG_ATIME = 5'h02;
  localparam raddr_t REG_PTIME = 5'h03;
  localparam raddr_t RO_LO     = 5'h0E;
  localparam raddr_t RO_HI     = 5'h13;
  localparam raddr_t NREG_A    = raddr_t'(NREG);

  localparam int CTRL_PWR  = 0;
  localparam int CTRL_SRST = 6;
  localparam int INTR_LFLG = 3;
  localparam int INTR_PFLG = 4;
  localparam int INTR_NEAR = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } eng_state_t;

  function automatic logic [7:0] reg_default(input raddr_t a);
    case (a)
      5'h01:                                     return 8'h40;
      5'h02, 5'h03, 5'h04, 5'h05, 5'h07, 5'h09, 5'h0B: return 8'hFF;
      5'h06, 5'h0A, 5'h0C:                       return 8'h03;
      5'h08:                                     return 8'hBF;
      default:                                   return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_regif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output raddr_t     ptr,
  output logic       wr_en,
  output raddr_t     wr_addr,
  output logic [7:0] wr_data
);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  eng_state_t state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txsh;
  logic       first_byte, rnw, mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bitcnt <= '0; shreg <= '0; txsh <= '0;
      first_byte <= 1'b0; rnw <= 1'b0; mack <= 1'b0;
      sda_oe <= 1'b0; ptr <= '0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR; bitcnt <= '0; first_byte <= 1'b1; sda_oe <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end
            if (scl_fall && bitcnt == BYTE_BITS) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == dev_addr) begin
                  sda_oe <= 1'b1; rnw <= shreg[0]; state <= ST_AACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_WACK;
                if (first_byte) begin
                  ptr        <= shreg[ADDR_W-1:0];
                  first_byte <= 1'b0;
                end else begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= shreg;
                  ptr     <= ptr + 5'd1;
                end
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            bitcnt <= '0;
            if (rnw) begin
              txsh <= rd_data; sda_oe <= ~rd_data[7]; state <= ST_RD;
            end else begin
              sda_oe <= 1'b0; state <= ST_WR;
            end
          end
          ST_WACK: if (scl_fall) begin
            sda_oe <= 1'b0; state <= ST_WR;
          end
          ST_RD: begin
            if (scl_rise) bitcnt <= bitcnt + 4'd1;
            if (scl_fall) begin
              if (bitcnt == BYTE_BITS) begin
                sda_oe <= 1'b0; state <= ST_RACK; ptr <= ptr + 5'd1; bitcnt <= '0;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              if (mack) begin
                txsh <= rd_data; sda_oe <= ~rd_data[7]; state <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  assert_idle_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);
  assert_drive_on_low_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  assert_ptr_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr == wr_addr + 5'd1));
endmodule

// File: rtl/i2c_sensor_regs.sv
module i2c_sensor_regs
  import i2c_regif_pkg::*;
#(
  parameter int PS_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  raddr_t            wr_addr,
  input  logic [7:0]        wr_data,
  input  raddr_t            rd_addr,
  output logic [7:0]        rd_data,
  input  logic [15:0]       light_val,
  input  logic [PS_W-1:0]   prox_val,
  input  logic [PS_W-1:0]   ir_val,
  input  logic              prox_near,
  input  logic              light_flag_set,
  input  logic              prox_flag_set,
  output logic [NREG*8-1:0] cfg_flat
);
  localparam int EXT_W = 16 - PS_W;

  logic [7:0]  regs [NREG];
  logic [15:0] prox_ext, ir_ext;
  logic        soft_rst, ro_hit;

  assign prox_ext = {{EXT_W{1'b0}}, prox_val};
  assign ir_ext   = {{EXT_W{1'b0}}, ir_val};
  assign soft_rst = wr_en && (wr_addr == REG_CTRL) && wr_data[CTRL_SRST];
  assign ro_hit   = (wr_addr >= RO_LO) && (wr_addr <= RO_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= reg_default(raddr_t'(i));
    end else begin
      if (soft_rst) begin
        for (int i = 0; i < NREG; i++) regs[i] <= reg_default(raddr_t'(i));
      end else if (wr_en && (wr_addr < NREG_A) && !ro_hit) begin
        case (wr_addr)
          REG_CTRL: regs[REG_CTRL] <= {wr_data[7], 1'b0, wr_data[5:3],
              wr_data[2:1] & {2{regs[REG_CTRL][CTRL_PWR] & wr_data[CTRL_PWR]}},
              wr_data[CTRL_PWR]};
          REG_INTR: regs[REG_INTR] <= {wr_data[7:6], 1'b0,
              regs[REG_INTR][INTR_PFLG:INTR_LFLG] & wr_data[INTR_PFLG:INTR_LFLG],
              wr_data[2:0]};
          REG_ATIME, REG_PTIME: if (wr_data != 8'h00) regs[wr_addr] <= wr_data;
          default: regs[wr_addr] <= wr_data;
        endcase
      end
      if (light_flag_set) regs[REG_INTR][INTR_LFLG] <= 1'b1;
      if (prox_flag_set)  regs[REG_INTR][INTR_PFLG] <= 1'b1;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr < NREG_A) rd_data = regs[rd_addr];
    case (rd_addr)
      REG_INTR: rd_data[INTR_NEAR] = prox_near;
      5'h0E: rd_data = light_val[7:0];
      5'h0F: rd_data = light_val[15:8];
      5'h10: rd_data = prox_ext[7:0];
      5'h11: rd_data = prox_ext[15:8];
      5'h12: rd_data = ir_ext[7:0];
      5'h13: rd_data = ir_ext[15:8];
      default: ;
    endcase
  end

  for (genvar g = 0; g < NREG; g++) begin : g_cfg
    assign cfg_flat[g*8 +: 8] = regs[g];
  end

  assert_time_zero_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_ATIME && wr_data == 8'h00) |=> $stable(regs[REG_ATIME]));
  assert_ptime_zero_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_PTIME && wr_data == 8'h00) |=> $stable(regs[REG_PTIME]));
  assert_enable_needs_power_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[REG_CTRL][2:1] != 2'b00) |-> regs[REG_CTRL][CTRL_PWR]);
  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (regs[REG_CTRL] == 8'h00 && regs[REG_ATIME] == 8'hFF));
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_INTR && !wr_data[INTR_LFLG] && !light_flag_set)
      |=> !regs[REG_INTR][INTR_LFLG]);
  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr >= NREG_A) |-> (rd_data == 8'h00));
endmodule

// File: rtl/i2c_sensor_regif.sv
module i2c_sensor_regif
  import i2c_regif_pkg::*;
#(
  parameter int         PS_W        = 10,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_LO     = 7'h5C,
  parameter logic [6:0] ADDR_HI     = 7'h23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_strap,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [15:0]       light_val,
  input  logic [PS_W-1:0]   prox_val,
  input  logic [PS_W-1:0]   ir_val,
  input  logic              prox_near,
  input  logic              light_flag_set,
  input  logic              prox_flag_set,
  output logic [NREG*8-1:0] cfg_flat
);
  logic   scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic   strap_q, strap_done, wr_en;
  raddr_t ptr, wr_addr;
  logic [7:0] wr_data, rd_data;
  logic [6:0] dev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q <= 1'b0; strap_done <= 1'b0;
    end else if (!strap_done) begin
      strap_q <= addr_strap; strap_done <= 1'b1;
    end
  end

  assign dev_addr = strap_q ? ADDR_HI : ADDR_LO;

  assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strap_done) |-> $stable(strap_q));

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2c_byte_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .dev_addr(dev_addr), .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  i2c_sensor_regs #(.PS_W(PS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data), .light_val(light_val), .prox_val(prox_val),
    .ir_val(ir_val), .prox_near(prox_near), .light_flag_set(light_flag_set),
    .prox_flag_set(prox_flag_set), .cfg_flat(cfg_flat));
endmodule

// File: tb/sim_i2c_sensor_regif.sv
`timescale 1ns/1ps
module sim_i2c_sensor_regif;
  localparam int H  = 8;
  localparam int WD = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_line;
  logic [15:0] light_val = 16'hA5C3;
  logic [9:0]  prox_val = 10'h2B7, ir_val = 10'h15E;
  logic near = 1'b0, lset = 1'b0, pset = 1'b0;
  logic [23*8-1:0] cfg_flat;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_sensor_regif u0 (
    .clk(clk), .rst_n(rst_n), .addr_strap(strap), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .light_val(light_val), .prox_val(prox_val), .ir_val(ir_val),
    .prox_near(near), .light_flag_set(lset), .prox_flag_set(pset), .cfg_flat(cfg_flat));

  function automatic logic [7:0] dflt(input int a);
    if (a == 1) return 8'h40;
    if (a == 2 || a == 3 || a == 4 || a == 5 || a == 7 || a == 9 || a == 11) return 8'hFF;
    if (a == 6 || a == 10 || a == 12) return 8'h03;
    if (a == 8) return 8'hBF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] ro_val(input int a);
    case (a)
      14: return light_val[7:0];
      15: return light_val[15:8];
      16: return prox_val[7:0];
      17: return {6'b0, prox_val[9:8]};
      18: return ir_val[7:0];
      default: return {6'b0, ir_val[9:8]};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; cyc(H); m_scl = 1'b1; cyc(H); m_sda = 1'b0; cyc(H); m_scl = 1'b0; cyc(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; cyc(H); m_scl = 1'b1; cyc(H); m_sda = 1'b1; cyc(H);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; cyc(H); m_scl = 1'b1; cyc(H); m_scl = 1'b0; cyc(2);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; cyc(H); m_scl = 1'b1; cyc(H/2); b = sda_line; cyc(H/2); m_scl = 1'b0; cyc(2);
  endtask

  task automatic tx_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rx_byte(input logic send_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(~send_ack);
  endtask

  task automatic do_write(input logic [6:0] dev, input int p, input int n);
    logic ack;
    bus_start();
    tx_byte({dev, 1'b0}, ack); chk("R4 address ack", ack, 1);
    tx_byte(8'(p), ack);       chk("R2 pointer byte ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      tx_byte(wbuf[k], ack); chk("R4 data byte ack", ack, 1);
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] dev, input int p, input int n);
    logic ack;
    bus_start();
    tx_byte({dev, 1'b0}, ack); chk("R4 address ack", ack, 1);
    tx_byte(8'(p), ack);       chk("R2 pointer byte ack", ack, 1);
    bus_start();
    tx_byte({dev, 1'b1}, ack); chk("R3 read address ack", ack, 1);
    for (int k = 0; k < n; k++) rx_byte(k < n - 1, rbuf[k]);
    cyc(4);
    chk("R5 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cyc(4); rst_n = 1'b1; cyc(6);
  endtask

  task automatic write1(input int p, input logic [7:0] v);
    wbuf[0] = v; do_write(7'h5C, p, 1);
  endtask

  initial begin : watchdog
    for (int c = 0; c < WD; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic ack;
    do_reset();
    chk("R5 idle after reset", sda_oe, 0);

    // R3 R6 R7 R8: full map after reset
    do_read(7'h5C, 0, 32);
    for (int a = 0; a < 32; a++) begin
      if (a >= 14 && a <= 19)  chk("R7 data register read", rbuf[a], ro_val(a));
      else if (a >= 23)        chk("R6 reserved reads zero", rbuf[a], 0);
      else                     chk("R8 default value", rbuf[a], dflt(a));
    end

    // R1: the other address gets no ACK
    bus_start(); tx_byte({7'h23, 1'b0}, ack); chk("R1 foreign address nack", ack, 0);
    chk("R1 line untouched", sda_oe, 0); bus_stop();

    // R2 R4 R6 R7: write sweep over 0x02..0x1F then read back
    for (int a = 2; a < 32; a++) wbuf[a-2] = pat(a);
    do_write(7'h5C, 2, 30);
    do_read(7'h5C, 0, 32);
    for (int a = 0; a < 32; a++) begin
      if (a < 2)                    chk("R2 untouched below sweep", rbuf[a], dflt(a));
      else if (a >= 14 && a <= 19)  chk("R7 write discarded", rbuf[a], ro_val(a));
      else if (a >= 23)             chk("R6 reserved write ignored", rbuf[a], 0);
      else                          chk("R2 auto-increment write", rbuf[a], pat(a));
    end

    // R3: wrap from 0x1F to 0x00
    do_read(7'h5C, 30, 3);
    chk("R3 wrap 0x1E", rbuf[0], 0);
    chk("R3 wrap 0x1F", rbuf[1], 0);
    chk("R3 wrap to 0x00", rbuf[2], 8'h00);

    // R10: zero writes to timing registers
    wbuf[0] = 8'h00; wbuf[1] = 8'h00; do_write(7'h5C, 2, 2);
    do_read(7'h5C, 2, 2);
    chk("R10 zero to 0x02 ignored", rbuf[0], pat(2));
    chk("R10 zero to 0x03 ignored", rbuf[1], pat(3));

    // R11: enable gating by power
    write1(0, 8'h07); do_read(7'h5C, 0, 1); chk("R11 enables blocked without power", rbuf[0], 8'h01);
    write1(0, 8'h07); do_read(7'h5C, 0, 1); chk("R11 enables latch with power", rbuf[0], 8'h07);
    write1(0, 8'h06); do_read(7'h5C, 0, 1); chk("R11 power off drops enables", rbuf[0], 8'h00);

    // R9: flags
    @(negedge clk); lset = 1'b1; pset = 1'b1; @(negedge clk); lset = 1'b0; pset = 1'b0;
    do_read(7'h5C, 1, 1); chk("R9 flags set", rbuf[0], 8'h58);
    write1(1, 8'h7F); do_read(7'h5C, 1, 1); chk("R9 write one keeps flags", rbuf[0], 8'h5F);
    write1(1, 8'h40); do_read(7'h5C, 1, 1); chk("R9 write zero clears flags", rbuf[0], 8'h40);
    near = 1'b1; do_read(7'h5C, 1, 1); chk("R9 near status bit", rbuf[0], 8'h60); near = 1'b0;

    // R8: soft reset
    write1(0, 8'h41);
    do_read(7'h5C, 0, 6);
    for (int a = 0; a < 6; a++) chk("R8 soft reset defaults", rbuf[a], dflt(a));

    // R1: strap high
    strap = 1'b1; do_reset();
    bus_start(); tx_byte({7'h5C, 1'b0}, ack); chk("R1 low address nack when strap high", ack, 0); bus_stop();
    do_read(7'h23, 2, 1); chk("R1 strap high address works", rbuf[0], 8'hFF);
    strap = 1'b0; cyc(4);
    do_read(7'h23, 5, 1); chk("R1 strap change after reset ignored", rbuf[0], 8'hFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule